// File: doc/BRIEF.md
# Soft-Configured Row Filter Scanner

This block decides, for each database row that streams past it one byte per clock, whether the row satisfies a compound filter expression. A bank of comparator elements each pulls one column field out of the byte stream and tests it against a stored constant. A binary tree of logic reducers then folds those single-bit outcomes into one qualify bit for the row.

Operators, constants, column byte ranges, disabled-element defaults and reducer functions all live in registers. These registers are written through a simple write port between rows. The same logic can therefore run any filter that maps onto a fully populated tree of the built-in size. Lopsided expressions fit by setting interior nodes to forward one child and by parking unused elements at a fixed value. The verdict for a row appears as a single-cycle `result_valid` pulse in the cycle after the row's final byte.

Top module: `rs_row_scanner`

## Requirements
- R1: After a synchronous active-high reset, `result_valid` and `result_qualify` are 0, and every configuration register is cleared: each element is disabled with a default value of 0, every reducer performs AND and every constant is zero. A row sent with this state yields qualify 0.
- R2: `result_valid` is high for exactly one cycle, namely the cycle after a cycle with `row_valid` and `row_last` both high. `result_qualify` is updated at that same moment and keeps its value until the next row ends.
- R3: Byte positions count from 0 at the first byte of each row. An element's field is built from the bytes whose position lies from its start to its stop position, both ends included. The first of these bytes is the most significant. The field is zero-extended to 64 bits. If the range holds more than 8 bytes, only the last 8 are kept. Bytes outside the range have no effect.
- R4: The comparison code, unsigned, is 0 EQ, 1 NE, 2 LT, 3 LE, 4 GT and 5 GE, with the relation read as field op constant. Codes 6 and 7 always evaluate false.
- R5: The reducer codes are 0 AND, 1 OR, 2 forward left child and 3 forward right child. Reducer k (0..6) is tree node k+1. Node n has children 2n (left) and 2n+1 (right). Element j is leaf node 8+j. Node 1 is the root and produces the qualify bit.
- R6: A disabled element outputs its programmed default bit, whatever the row contents.
- R7: Configuration address: address bits [4:3] select the space and bits [2:0] select the index. Space 0 is the element control word: data bits [2:0] hold the comparison, bit 3 the enable, bit 4 the disabled default, [15:8] the start position and [23:16] the stop position. Space 1 is the element's 64-bit constant. Space 2 is the reducer code, in data bits [1:0].
- R8: A configuration write is discarded when `row_valid` is high, and also at any time between the first byte of a row and its last byte. Rows keep using the configuration that was in place when they began.
- R9: The byte position restarts at 0 after every last byte, including for single-byte rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address (space and index) |
| cfg_wdata | input | 64 | Configuration write data |
| row_valid | input | 1 | Row byte present this cycle |
| row_data | input | 8 | Row byte |
| row_last | input | 1 | Marks the final byte of a row |
| result_valid | output | 1 | One-cycle pulse after a row ends |
| result_qualify | output | 1 | Filter verdict for the row just ended |

## Verification
The hardest situation to provoke is a configuration write that arrives while a row is only partly delivered. This includes a write during an idle gap between two bytes of the same row, and a write in the same cycle as a row's first byte. The bench stalls a row mid-stream, issues writes in both of those windows, and then finishes the row. It then sends a second row whose verdict would change if either write had landed. A field range longer than eight bytes and single-byte rows are also driven on purpose, because they exercise the truncation rule and the position restart.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] CMP_EQ = 3'd0;
  localparam logic [2:0] CMP_NE = 3'd1;
  localparam logic [2:0] CMP_LT = 3'd2;
  localparam logic [2:0] CMP_LE = 3'd3;
  localparam logic [2:0] CMP_GT = 3'd4;
  localparam logic [2:0] CMP_GE = 3'd5;

  localparam logic [1:0] RED_AND   = 2'd0;
  localparam logic [1:0] RED_OR    = 2'd1;
  localparam logic [1:0] RED_LEFT  = 2'd2;
  localparam logic [1:0] RED_RIGHT = 2'd3;

  localparam logic [1:0] SPACE_CTRL  = 2'd0;
  localparam logic [1:0] SPACE_CONST = 2'd1;
  localparam logic [1:0] SPACE_RED   = 2'd2;
endpackage

// File: rtl/rs_pred_elem.sv
module rs_pred_elem
  import rs_pkg::*;
#(
  parameter int FIELD_W = 64,
  parameter int POS_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               row_valid,
  input  logic [POS_W-1:0]   pos,
  input  logic [BYTE_W-1:0]  byte_in,
  input  logic [2:0]         op,
  input  logic               en,
  input  logic               dis_val,
  input  logic [POS_W-1:0]   start_pos,
  input  logic [POS_W-1:0]   stop_pos,
  input  logic [FIELD_W-1:0] konst,
  output logic               hit
);
  logic [FIELD_W-1:0] field_q, base, field_nxt;
  logic               in_rng, cmp;

  always_comb begin
    base      = (pos == '0) ? '0 : field_q;
    in_rng    = (pos >= start_pos) && (pos <= stop_pos);
    field_nxt = in_rng ? {base[FIELD_W-BYTE_W-1:0], byte_in} : base;
  end

  always_ff @(posedge clk) begin
    if (rst)            field_q <= '0;
    else if (row_valid) field_q <= field_nxt;
  end

  always_comb begin
    case (op)
      CMP_EQ:  cmp = (field_nxt == konst);
      CMP_NE:  cmp = (field_nxt != konst);
      CMP_LT:  cmp = (field_nxt <  konst);
      CMP_LE:  cmp = (field_nxt <= konst);
      CMP_GT:  cmp = (field_nxt >  konst);
      CMP_GE:  cmp = (field_nxt >= konst);
      default: cmp = 1'b0;
    endcase
    hit = en ? cmp : dis_val;
  end

  // R3: the captured field only moves while row bytes are arriving
  a_r3_field_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !row_valid |=> $stable(field_q));
endmodule

// File: rtl/rs_reduce_tree.sv
module rs_reduce_tree
  import rs_pkg::*;
#(
  parameter int NUM_LEAF = 8
) (
  input  logic [NUM_LEAF-1:0]       leaf,
  input  logic [2*(NUM_LEAF-1)-1:0] ru_ops,
  output logic                      root
);
  logic nd [1:2*NUM_LEAF-1];

  for (genvar j = 0; j < NUM_LEAF; j++) begin : g_leaf
    assign nd[NUM_LEAF+j] = leaf[j];
  end

  for (genvar n = 1; n < NUM_LEAF; n++) begin : g_ru
    logic [1:0] code;
    logic       lft, rgt;
    assign code  = ru_ops[2*(n-1) +: 2];
    assign lft   = nd[2*n];
    assign rgt   = nd[2*n+1];
    assign nd[n] = (code == RED_AND)  ? (lft & rgt) :
                   (code == RED_OR)   ? (lft | rgt) :
                   (code == RED_LEFT) ? lft : rgt;
  end

  assign root = nd[1];
endmodule

// File: rtl/rs_row_scanner.sv
module rs_row_scanner
  import rs_pkg::*;
#(
  parameter int NUM_PE  = 8,
  parameter int FIELD_W = 64,
  parameter int POS_W   = 8,
  localparam int IDX_W  = $clog2(NUM_PE),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [FIELD_W-1:0] cfg_wdata,
  input  logic               row_valid,
  input  logic [BYTE_W-1:0]  row_data,
  input  logic               row_last,
  output logic               result_valid,
  output logic               result_qualify
);
  localparam int NUM_RU = NUM_PE - 1;

  logic [2:0]         pe_op    [NUM_PE];
  logic               pe_en    [NUM_PE];
  logic               pe_dv    [NUM_PE];
  logic [POS_W-1:0]   pe_start [NUM_PE];
  logic [POS_W-1:0]   pe_stop  [NUM_PE];
  logic [FIELD_W-1:0] pe_const [NUM_PE];
  logic [2*NUM_RU-1:0] ru_ops;

  logic               busy_q;
  logic [POS_W-1:0]   pos_q;
  logic [NUM_PE-1:0]  hits;
  logic               root;
  logic               cfg_ok;
  logic [1:0]         space;
  logic [IDX_W-1:0]   idx;

  assign space  = cfg_addr[ADDR_W-1 -: 2];
  assign idx    = cfg_addr[IDX_W-1:0];
  assign cfg_ok = cfg_we && !busy_q && !row_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ru_ops <= '0;
      for (int i = 0; i < NUM_PE; i++) begin
        pe_op[i] <= CMP_EQ; pe_en[i] <= 1'b0; pe_dv[i] <= 1'b0;
        pe_start[i] <= '0; pe_stop[i] <= '0; pe_const[i] <= '0;
      end
    end else if (cfg_ok) begin
      case (space)
        SPACE_CTRL: begin
          pe_op[idx]    <= cfg_wdata[2:0];
          pe_en[idx]    <= cfg_wdata[3];
          pe_dv[idx]    <= cfg_wdata[4];
          pe_start[idx] <= cfg_wdata[8 +: POS_W];
          pe_stop[idx]  <= cfg_wdata[8+POS_W +: POS_W];
        end
        SPACE_CONST: pe_const[idx] <= cfg_wdata;
        SPACE_RED:
          if ({1'b0, idx} < (IDX_W+1)'(NUM_RU)) ru_ops[2*idx +: 2] <= cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (row_valid) begin
      busy_q <= !row_last;
      pos_q  <= row_last ? '0 : pos_q + 1'b1;
    end
  end

  for (genvar j = 0; j < NUM_PE; j++) begin : g_pe
    rs_pred_elem #(.FIELD_W(FIELD_W), .POS_W(POS_W)) pe_i (
      .clk(clk), .rst(rst), .row_valid(row_valid), .pos(pos_q),
      .byte_in(row_data), .op(pe_op[j]), .en(pe_en[j]), .dis_val(pe_dv[j]),
      .start_pos(pe_start[j]), .stop_pos(pe_stop[j]), .konst(pe_const[j]),
      .hit(hits[j]));
  end

  rs_reduce_tree #(.NUM_LEAF(NUM_PE)) tree_i (
    .leaf(hits), .ru_ops(ru_ops), .root(root));

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid   <= 1'b0;
      result_qualify <= 1'b0;
    end else begin
      result_valid <= row_valid && row_last;
      if (row_valid && row_last) result_qualify <= root;
    end
  end

  // R1: reset leaves the result outputs low
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !result_valid && !result_qualify);
  // R2: a last byte is always followed by a result pulse
  a_r2_valid_follows_last: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_last |=> result_valid);
  // R2: no pulse without a last byte in the cycle before
  a_r2_valid_needs_last: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(row_valid && row_last));
  // R2: the verdict holds between row ends
  a_r2_qualify_hold: assert property (@(posedge clk) disable iff (rst)
    !(row_valid && row_last) |=> $stable(result_qualify));
  // R9: position restarts after every last byte
  a_r9_pos_restart: assert property (@(posedge clk) disable iff (rst)
    row_valid && row_last |=> pos_q == '0);
  // R8: configuration frozen while a row is in flight
  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    (busy_q || row_valid) |=> $stable(pe_const[0]) && $stable(pe_op[0]) && $stable(ru_ops));
endmodule

// File: tb/rs_row_scanner_tb_top.sv
module rs_row_scanner_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        row_valid = 1'b0;
  logic [7:0]  row_data = '0;
  logic        row_last = 1'b0;
  logic        result_valid, result_qualify;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rs_row_scanner dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .row_valid(row_valid), .row_data(row_data),
    .row_last(row_last), .result_valid(result_valid),
    .result_qualify(result_qualify));

  // bit 64: expected qualify, bits 63:0: eight row bytes, first byte in 63:56
  localparam logic [64:0] VEC [10] = '{
    {1'b1, 64'h2000_5501_0000_FF00},
    {1'b0, 64'h1000_5501_0000_FF00},
    {1'b0, 64'h2000_5401_0000_FF00},
    {1'b0, 64'h2000_5502_0000_FF00},
    {1'b1, 64'h2000_5502_0007_FF00},
    {1'b1, 64'h0000_0000_0000_8010},
    {1'b0, 64'h0000_0000_0000_8110},
    {1'b0, 64'h0000_0000_0000_800F},
    {1'b1, 64'hFFFF_5500_0000_00FF},
    {1'b0, 64'hFFFF_55FF_FF00_0000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pe(input int i, input logic [2:0] op, input bit en, input bit dv,
                    input int s, input int e, input logic [63:0] k);
    wr(5'(i), {40'd0, 8'(e), 8'(s), 3'd0, dv, en, op});
    wr(5'(8 + i), k);
  endtask

  task automatic ru(input int k, input logic [1:0] code);
    wr(5'(16 + k), {62'd0, code});
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last);
    row_valid = 1'b1; row_data = b; row_last = last;
    @(negedge clk);
    row_valid = 1'b0; row_last = 1'b0;
  endtask

  task automatic send_row(input logic [127:0] bytes, input int len);
    for (int i = 0; i < len; i++) send_byte(bytes[127-8*i -: 8], i == len - 1);
  endtask

  task automatic row_check(input string tag, input logic [127:0] bytes, input int len, input bit exp);
    send_row(bytes, len);
    chk({tag, " valid"}, 64'(result_valid), 64'd1);
    chk(tag, 64'(result_qualify), 64'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset valid", 64'(result_valid), 64'd0);
    chk("R1 reset qualify", 64'(result_qualify), 64'd0);
    row_check("R1 default config row", {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, 8, 1'b0);
    // R2: single-cycle pulse, held verdict
    @(negedge clk);
    chk("R2 pulse ends", 64'(result_valid), 64'd0);
    chk("R2 qualify held", 64'(result_qualify), 64'd0);

    // table configuration (R4, R5, R7): codes EQ0 NE1 LT2 LE3 GT4 GE5
    pe(0, 3'd4, 1, 0, 0, 1, 64'h1000);
    pe(1, 3'd0, 1, 0, 2, 2, 64'h55);
    pe(2, 3'd2, 1, 0, 3, 4, 64'h0200);
    pe(3, 3'd1, 1, 0, 5, 5, 64'h00);
    pe(4, 3'd3, 1, 0, 6, 6, 64'h80);
    pe(5, 3'd5, 1, 0, 7, 7, 64'h10);
    pe(6, 3'd0, 0, 0, 0, 0, 64'h0);
    pe(7, 3'd0, 0, 0, 0, 0, 64'h0);
    ru(3, 2'd0); ru(4, 2'd1); ru(5, 2'd0); ru(6, 2'd2);
    ru(1, 2'd0); ru(2, 2'd1); ru(0, 2'd1);
    for (int v = 0; v < 10; v++) begin
      row_check($sformatf("R4/R5 table vector %0d", v), {VEC[v][63:0], 64'd0}, 8, VEC[v][64]);
    end

    // R8: write during a gap inside a row, and in a cycle with row_valid high
    send_byte(8'h20, 0); send_byte(8'h00, 0); send_byte(8'h55, 0);
    wr(5'd9, 64'h54);
    send_byte(8'h01, 0); send_byte(8'h00, 0); send_byte(8'h00, 0);
    send_byte(8'hFF, 0); send_byte(8'h00, 1);
    chk("R8 mid-row write ignored", 64'(result_qualify), 64'd1);
    cfg_we = 1'b1; cfg_addr = 5'd9; cfg_wdata = 64'h54;
    send_byte(8'h20, 0);
    cfg_we = 1'b0;
    send_row({56'h00_5501_0000_FF00, 72'd0}, 7);
    chk("R8 writes did not land", 64'(result_qualify), 64'd1);

    // single element forwarded to the root (R5 forward-left)
    ru(0, 2'd2); ru(1, 2'd2); ru(3, 2'd2);
    pe(0, 3'd0, 1, 0, 0, 0, 64'hA5);
    row_check("R9 one-byte row match", {8'hA5, 120'd0}, 1, 1'b1);
    row_check("R9 one-byte row mismatch", {8'hA4, 120'd0}, 1, 1'b0);
    row_check("R9 R3 restart, tail ignored", {24'hA5_1122, 104'd0}, 3, 1'b1);
    // R3: long range keeps the last eight bytes
    pe(0, 3'd0, 1, 0, 0, 9, 64'h0203_0405_0607_0809);
    row_check("R3 long range truncation", {80'h0001_0203_0405_0607_0809, 48'd0}, 10, 1'b1);
    // R3: zero extension of a middle range
    pe(0, 3'd0, 1, 0, 1, 3, 64'h0A0B0C);
    row_check("R3 zero extended field", {40'hFF_0A0B_0CFF, 88'd0}, 5, 1'b1);
    // R4: unused codes evaluate false
    pe(0, 3'd6, 1, 0, 0, 0, 64'hA5);
    row_check("R4 code 6 false", {8'hA5, 120'd0}, 1, 1'b0);
    pe(0, 3'd7, 1, 0, 0, 0, 64'hA5);
    row_check("R4 code 7 false", {8'hA5, 120'd0}, 1, 1'b0);
    // R6: disabled element default through forward-right path
    ru(0, 2'd3); ru(2, 2'd3); ru(6, 2'd2);
    pe(6, 3'd0, 0, 1, 0, 0, 64'h77);
    row_check("R6 disabled default 1", {8'h00, 120'd0}, 1, 1'b1);
    pe(6, 3'd0, 0, 0, 0, 0, 64'h00);
    row_check("R6 disabled default 0", {8'h00, 120'd0}, 1, 1'b0);

    // R1: reset restores cleared configuration
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset again valid", 64'(result_valid), 64'd0);
    row_check("R1 config cleared", {8'h00, 120'd0}, 1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule